// File: doc/BRIEF.md
# Pipeline Exception Status Tracker

This block follows a two-bit status code for every instruction in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Fetch classifies each new instruction from its fetch address and opcode. Decode and execute pass the code along unchanged. The memory stage may replace an AOK code with a bad-address code when the data access is invalid. A fault takes effect only when its instruction reaches writeback. At that point the block raises `halt`, reports the code on `final_status`, and freezes every pipeline register until reset.

The datapath uses the block's permission outputs as enables. `cc_write_en` allows the instruction in execute to update the condition codes. It drops in the same cycle that an older instruction in memory or writeback carries a fault. `dmem_write_en` allows the instruction in memory to write data memory. It is never high for a flagged address. `rf_write_en` allows the instruction in writeback to commit to the register file.

Branch misprediction squashes the two youngest instructions, so their faults never surface. A load-use stall holds fetch and decode and sends a bubble into execute. Every bubble carries AOK.

Top module: `exc_status_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, all four stage registers (decode through writeback) become bubbles. After that edge `halt`, `cc_write_en`, `dmem_write_en` and `rf_write_en` are 0, and `final_status` is 2'b00.
- R2: Fetch assigns a status with the encoding AOK=2'b00, HLT=2'b01, ADR=2'b10, INS=2'b11. The priority is: ADR if `fetch_addr_bad`, else INS if `opcode_valid` is 0, else HLT if `is_halt`, else AOK.
- R3: The status is unchanged through decode and execute. Without stalls or squashes, an instruction fetched in cycle t is in writeback in cycle t+4. If its status is non-AOK, `halt` is 1 in that cycle.
- R4: In memory, a valid instruction with AOK status and `mem_addr_bad`=1 moves to writeback with ADR. Any other valid instruction keeps its status. `mem_addr_bad` has no effect when memory holds a bubble.
- R5: `cc_write_en` is 1 exactly when execute holds a valid AOK instruction, memory holds no faulting instruction (after the R4 override), and writeback holds no faulting instruction.
- R6: `dmem_write_en` is 1 exactly when memory holds a valid instruction whose status after the R4 override is AOK, and writeback holds no faulting instruction.
- R7: `rf_write_en` is 1 exactly when writeback holds a valid AOK instruction.
- R8: When `mispredict` is 1 at an edge, the instruction being fetched and the instruction in decode are both replaced by bubbles. Their status never reaches writeback. `mispredict` takes priority over `stall`.
- R9: When `stall` is 1 at an edge and `mispredict` is 0, decode keeps its instruction, the current fetch is dropped, and execute receives a bubble. Memory and writeback advance normally.
- R10: While `halt` is 1, every stage register holds at each edge, ignoring all inputs except `rst`. Therefore `halt` and `final_status` stay constant until reset. `final_status` equals the writeback status while `halt` is 1 and is 2'b00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr_bad | input | 1 | Fetch address is invalid |
| opcode_valid | input | 1 | Fetched opcode is recognised |
| is_halt | input | 1 | Fetched opcode is the halt instruction |
| mem_addr_bad | input | 1 | Data access of the memory-stage instruction is invalid |
| mispredict | input | 1 | Branch in execute was mispredicted |
| stall | input | 1 | Load-use stall request |
| cc_write_en | output | 1 | Execute may update condition codes |
| dmem_write_en | output | 1 | Memory stage may write data memory |
| rf_write_en | output | 1 | Writeback may commit to the register file |
| halt | output | 1 | A faulting instruction is in writeback |
| final_status | output | 2 | Status of the halting instruction, AOK otherwise |

## Verification
The block has a fixed depth and no tunable parameters, so the bench builds its single configuration. The randomised phases vary the rates of faults, stalls and mispredicts. This reaches overlaps such as a memory-stage override under an older writeback fault, and a stall and a squash arriving in the same cycle. Directed sequences target three cases:
- a squash of an illegal opcode;
- a data-address fault on a bubble;
- a frozen halt that ignores further inputs.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        ST_AOK = 2'b00,
        ST_HLT = 2'b01,
        ST_ADR = 2'b10,
        ST_INS = 2'b11
    } stat_e;

    typedef struct packed {
        logic  valid;
        stat_e stat;
    } slot_t;

    // Latched stages after fetch: decode, execute, memory, writeback
    localparam int NUM_LATCHED = 4;
    localparam int IDX_DEC = 0;
    localparam int IDX_EXE = 1;
    localparam int IDX_MEM = 2;
    localparam int IDX_WB  = NUM_LATCHED - 1;

    localparam slot_t BUBBLE = '{valid: 1'b0, stat: ST_AOK};

    function automatic logic slot_faulty(slot_t s);
        return s.valid && (s.stat != ST_AOK);
    endfunction

endpackage

// File: rtl/exc_fetch_classify.sv
module exc_fetch_classify
    import exc_pkg::*;
(
    input  logic  addr_bad,
    input  logic  op_ok,
    input  logic  op_halt,
    output stat_e stat
);
    always_comb begin
        if (addr_bad)      stat = ST_ADR;
        else if (!op_ok)   stat = ST_INS;
        else if (op_halt)  stat = ST_HLT;
        else               stat = ST_AOK;
    end

    always_comb begin
        if (addr_bad) a_r2_addr_first: assert (stat == ST_ADR);
    end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  bubble,
    input  slot_t din,
    output slot_t dout
);
    always_ff @(posedge clk) begin
        if (rst)          dout <= BUBBLE;
        else if (hold)    dout <= dout;
        else if (bubble)  dout <= BUBBLE;
        else              dout <= din;
    end

    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dout));
    a_r8_bubble_aok: assert property (@(posedge clk) disable iff (rst)
        (bubble && !hold) |=> (!dout.valid && dout.stat == ST_AOK));
endmodule

// File: rtl/exc_side_effect_gate.sv
module exc_side_effect_gate
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t exe_slot,
    input  slot_t mem_slot,
    input  slot_t wb_slot,
    output logic  cc_en,
    output logic  dm_en,
    output logic  rf_en,
    output logic  wb_fault,
    output stat_e wb_stat
);
    logic mem_fault;

    always_comb begin
        wb_fault  = slot_faulty(wb_slot);
        mem_fault = slot_faulty(mem_slot);
        cc_en     = exe_slot.valid && (exe_slot.stat == ST_AOK)
                    && !mem_fault && !wb_fault;
        dm_en     = mem_slot.valid && (mem_slot.stat == ST_AOK) && !wb_fault;
        rf_en     = wb_slot.valid && (wb_slot.stat == ST_AOK);
        wb_stat   = wb_fault ? wb_slot.stat : ST_AOK;
    end

    a_r5_cc_blocked: assert property (@(posedge clk) disable iff (rst)
        (mem_fault || wb_fault) |-> !cc_en);
    a_r7_rf_blocked: assert property (@(posedge clk) disable iff (rst)
        wb_fault |-> !rf_en);
endmodule

// File: rtl/exc_status_pipe.sv
module exc_status_pipe
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch_addr_bad,
    input  logic       opcode_valid,
    input  logic       is_halt,
    input  logic       mem_addr_bad,
    input  logic       mispredict,
    input  logic       stall,
    output logic       cc_write_en,
    output logic       dmem_write_en,
    output logic       rf_write_en,
    output logic       halt,
    output logic [1:0] final_status
);
    stat_e fetch_stat;
    stat_e wb_stat;
    slot_t stg_q   [NUM_LATCHED];
    slot_t stg_d   [NUM_LATCHED];
    logic  stg_hold[NUM_LATCHED];
    logic  stg_bub [NUM_LATCHED];
    slot_t mem_eff;
    logic  wb_fault;

    exc_fetch_classify u_fetch (
        .addr_bad (fetch_addr_bad),
        .op_ok    (opcode_valid),
        .op_halt  (is_halt),
        .stat     (fetch_stat)
    );

    // Memory stage may overwrite an AOK status with a bad data address
    always_comb begin
        mem_eff = stg_q[IDX_MEM];
        if (mem_eff.valid && mem_eff.stat == ST_AOK && mem_addr_bad)
            mem_eff.stat = ST_ADR;
    end

    always_comb begin
        for (int i = 0; i < NUM_LATCHED; i++) begin
            stg_hold[i] = wb_fault;
            stg_bub[i]  = 1'b0;
            stg_d[i]    = (i == 0) ? BUBBLE : stg_q[(i == 0) ? 0 : i - 1];
        end
        stg_d[IDX_DEC]    = '{valid: 1'b1, stat: fetch_stat};
        stg_hold[IDX_DEC] = wb_fault || (stall && !mispredict);
        stg_bub[IDX_DEC]  = mispredict;
        stg_bub[IDX_EXE]  = mispredict || stall;
        stg_d[IDX_WB]     = mem_eff;
    end

    for (genvar g = 0; g < NUM_LATCHED; g++) begin : g_stage
        exc_stage_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .hold   (stg_hold[g]),
            .bubble (stg_bub[g]),
            .din    (stg_d[g]),
            .dout   (stg_q[g])
        );
    end

    exc_side_effect_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .exe_slot (stg_q[IDX_EXE]),
        .mem_slot (mem_eff),
        .wb_slot  (stg_q[IDX_WB]),
        .cc_en    (cc_write_en),
        .dm_en    (dmem_write_en),
        .rf_en    (rf_write_en),
        .wb_fault (wb_fault),
        .wb_stat  (wb_stat)
    );

    assign halt         = wb_fault;
    assign final_status = wb_stat;

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && $stable(final_status)));
    a_r6_no_bad_write: assert property (@(posedge clk) disable iff (rst)
        mem_addr_bad |-> !dmem_write_en);
    a_r10_idle_final_aok: assert property (@(posedge clk) disable iff (rst)
        !halt |-> (final_status == 2'b00));
    a_r4_override_adr: assert property (@(posedge clk) disable iff (rst)
        (!halt && stg_q[IDX_MEM].valid && stg_q[IDX_MEM].stat == ST_AOK && mem_addr_bad)
        |=> (halt && final_status == 2'b10));
endmodule

// File: tb/exc_status_pipe_tb.sv
module exc_status_pipe_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fab = 1'b0, ov = 1'b1, ih = 1'b0, mab = 1'b0, mis = 1'b0, stl = 1'b0;
    logic cc, dm, rf, hl;
    logic [1:0] fs;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    // Reference: -1 means bubble, otherwise status code; order D,E,M,W
    int ref_q[4] = '{-1, -1, -1, -1};

    always #4 clk = ~clk;

    exc_status_pipe u_dut (
        .clk(clk), .rst(rst), .fetch_addr_bad(fab), .opcode_valid(ov),
        .is_halt(ih), .mem_addr_bad(mab), .mispredict(mis), .stall(stl),
        .cc_write_en(cc), .dmem_write_en(dm), .rf_write_en(rf),
        .halt(hl), .final_status(fs)
    );

    function automatic int fetch_code();
        if (fab) return 2;
        if (!ov) return 3;
        if (ih)  return 1;
        return 0;
    endfunction

    function automatic int mem_code();
        if (ref_q[2] < 0) return -1;
        if (ref_q[2] == 0 && mab) return 2;
        return ref_q[2];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        int me = mem_code();
        int wb = ref_q[3];
        bit wf = (wb > 0);
        chk("R3 halt", hl, wf);
        chk("R2/R10 final_status", fs, wf ? wb : 0);
        chk("R5 cc_write_en", cc, (ref_q[1] == 0) && !(me > 0) && !wf);
        chk("R6 dmem_write_en", dm, (me == 0) && !wf);
        chk("R7 rf_write_en", rf, wb == 0);
    endtask

    task automatic model_edge();
        if (rst) begin
            ref_q = '{-1, -1, -1, -1};
        end else if (!(ref_q[3] > 0)) begin
            int me = mem_code();
            int f  = fetch_code();
            ref_q[3] = me;
            ref_q[2] = ref_q[1];
            ref_q[1] = (mis || stl) ? -1 : ref_q[0];
            ref_q[0] = mis ? -1 : (stl ? ref_q[0] : f);
        end
    endtask

    // One cycle: inputs already set after negedge; compare, then take the edge
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
    endtask

    task automatic set_in(input bit a, input bit o, input bit h, input bit m,
                          input bit p, input bit s);
        fab = a; ov = o; ih = h; mab = m; mis = p; stl = s;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        set_in(0, 1, 0, 0, 0, 0);
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic rand_phase(input int n, input int fpct, input int mpct,
                              input int spct, input int ppct);
        for (int k = 0; k < n; k++) begin
            set_in($urandom_range(0, 99) < fpct, !($urandom_range(0, 99) < fpct),
                   $urandom_range(0, 99) < fpct, $urandom_range(0, 99) < mpct,
                   $urandom_range(0, 99) < ppct, $urandom_range(0, 99) < spct);
            step();
            if (ref_q[3] > 0 && $urandom_range(0, 3) == 0) do_reset();
        end
    endtask

    initial begin : watchdog
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: state after reset
        #1;
        chk("R1 halt after reset", hl, 0);
        chk("R1 enables after reset", {cc, dm, rf}, 0);
        chk("R1 final_status after reset", fs, 0);

        // R2, R3: each fetch class reaches writeback after four edges
        for (int c = 0; c < 4; c++) begin
            do_reset();
            case (c)
                0: set_in(1, 0, 1, 0, 0, 0);
                1: set_in(0, 0, 1, 0, 0, 0);
                2: set_in(0, 1, 1, 0, 0, 0);
                default: set_in(0, 1, 0, 0, 0, 0);
            endcase
            step();
            set_in(0, 1, 0, 0, 0, 0);
            for (int k = 0; k < 3; k++) step();
            #1;
            chk("R2 fetch priority final_status", fs, (c == 0) ? 2 : (c == 1) ? 3 : (c == 2) ? 1 : 0);
            chk("R3 halt at t+4", hl, c != 3);
            step();
        end

        // R4: data-address fault on a bubble is ignored
        do_reset();
        set_in(0, 1, 0, 1, 0, 0);
        step();
        step();
        #1;
        chk("R4 bubble ignores mem_addr_bad", hl, 0);
        step();
        // now a valid AOK in memory with bad address
        #1;
        chk("R6 bad addr blocks write", dm, 0);
        step();
        #1;
        chk("R4 override to ADR", fs, 2);

        // R8: illegal opcode squashed by mispredict never halts
        do_reset();
        set_in(0, 1, 0, 0, 0, 0);
        step();
        set_in(0, 0, 0, 0, 0, 0);
        step();
        set_in(0, 0, 0, 0, 1, 1);
        step();
        set_in(0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) step();
        #1;
        chk("R8 squashed INS never halts", hl, 0);
        step();

        // R9: stall inserts a bubble into execute
        do_reset();
        set_in(0, 1, 0, 0, 0, 0);
        step();
        set_in(0, 1, 0, 0, 0, 1);
        step();
        #1;
        chk("R9 stall bubble in execute", cc, 0);
        step();

        // R10: frozen halt ignores further inputs
        do_reset();
        set_in(0, 1, 1, 0, 0, 0);
        step();
        set_in(0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step();
        set_in(1, 0, 0, 1, 1, 1);
        for (int k = 0; k < 4; k++) step();
        #1;
        chk("R10 halt sticky", hl, 1);
        chk("R10 final_status frozen", fs, 1);
        step();

        do_reset();
        rand_phase(3000, 2, 2, 15, 10);
        do_reset();
        rand_phase(3000, 10, 10, 30, 25);
        do_reset();
        rand_phase(2000, 0, 0, 40, 40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule